// File: doc/BRIEF.md
# Wide Register Read Snapshot Buffer

This block lets a processor read a register that is wider than its bus access width without tearing. The register is split into `REG_W/ACC_W` sub-words. The block takes a set of live field values and packs them into one register-wide word. Unused bit positions are forced to zero, and fields declared in reversed orientation are bit-swapped into their slot. On a trigger event the packed word is copied into a holding buffer. Every sub-word read then returns data from that buffer, so a multi-access read sees one consistent value even while the live fields keep moving.

The trigger source is fixed by a parameter, with three choices:
- **Self-read:** a read of sub-word 0.
- **External pin:** a dedicated input whose active level is set by a parameter.
- **Field bit:** a one-bit field value, used as-is with no qualification.

In the cycle that captures, a read returns the freshly packed value rather than the old buffer. A capturing read of sub-word 0 is therefore already part of the new snapshot. Address decoding and write handling live outside the block. It sees only one decoded strobe per sub-word and a write flag.

Top module: `wide_snap_buf`

## Requirements
- R1: A synchronous active-high reset clears the holding buffer to zero, so after reset every non-capturing sub-word read returns zero.
- R2: The buffer loads the packed word only in a clock cycle in which the trigger is active, and holds its value in every other cycle.
- R3: With the self-read source, the trigger is active exactly when `req_stb[0]` is 1 and `req_is_wr` is 0. Writes to sub-word 0 and reads of any other sub-word do not capture.
- R4: With the external-pin source, `ext_trig` triggers at level 1 when `EXT_ACT_HIGH` is 1, and at level 0 otherwise. Strobes and the write flag then have no effect on capture.
- R5: With the field-bit source, `fld_trig` = 1 triggers capture regardless of strobes or the write flag.
- R6: Word bits not covered by any field are zero in the captured word: below the first field, between fields and above the last. Lane bits of `fld_value` above a field's width are ignored. The default layout is: field 0 at word bits [15:4] (12 bits), field 1 at [35:20] (16 bits, reversed), field 2 at [55:40] (16 bits).
- R7: For a field marked reversed, lane bit `W-1-b` lands at word bit `LO+b`. With the default layout, field 1 lane bit 0 appears at word bit 35, and lane bit 15 appears at word bit 20.
- R8: `req_stb` has at most one bit set. A read with `req_stb[k]` = 1 returns bits `[k*ACC_W +: ACC_W]` of the buffer.
- R9: In a cycle where the trigger is active, a read returns the corresponding slice of the freshly packed live word.
- R10: `rd_data` is zero when no strobe is set or when `req_is_wr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_stb | input | REG_W/ACC_W | Decoded access strobe, one bit per sub-word |
| req_is_wr | input | 1 | The current access is a write |
| ext_trig | input | 1 | External capture trigger, polarity set by EXT_ACT_HIGH |
| fld_trig | input | 1 | One-bit field value used as a capture trigger |
| fld_value | input | NFLD x FLD_MAXW | Live field values, one lane per field |
| rd_data | output | ACC_W | Read data for the strobed sub-word |

## Verification
Random field patterns are captured by a sub-word 0 read. The fields are then changed before each higher sub-word is read. This separates a true snapshot from a live pass-through, and from a buffer that reloads on every read.

An all-ones pattern exposes any gap bit that is not zero-filled. Single-bit patterns in the reversed field tell a correct bit swap from a straight copy.

Three instances share their inputs, one per trigger source. Each one is driven with the other sources' trigger conditions to show that only its own source captures. Writes to sub-word 0, idle cycles and a mid-run reset complete the set.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    // Source of the event that loads the holding buffer
    typedef enum logic [1:0] {
        TRIG_SELF_READ = 2'd0,   // read access to sub-word 0
        TRIG_EXT_PIN   = 2'd1,   // dedicated trigger input
        TRIG_FIELD_BIT = 2'd2    // one-bit field value
    } trig_src_e;

endpackage

// File: rtl/wsb_field_pack.sv
module wsb_field_pack #(
    parameter int REG_W    = 64,
    parameter int NFLD     = 3,
    parameter int FLD_MAXW = 16,
    parameter int FLD_LO  [NFLD] = '{4, 20, 40},
    parameter int FLD_W   [NFLD] = '{12, 16, 16},
    parameter bit FLD_REV [NFLD] = '{1'b0, 1'b1, 1'b0}
) (
    input  logic [NFLD-1:0][FLD_MAXW-1:0] fld_value,
    output logic [REG_W-1:0]              packed_word
);

    // Each field contributes one zero-padded slot; slots are OR-merged
    logic [NFLD:0][REG_W-1:0] merge;
    assign merge[0] = '0;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        logic [REG_W-1:0] slot;
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            if (b >= FLD_LO[g] && b < FLD_LO[g] + FLD_W[g]) begin : g_in
                localparam int OFS = b - FLD_LO[g];
                localparam int SRC = FLD_REV[g] ? (FLD_W[g] - 1 - OFS) : OFS;
                assign slot[b] = fld_value[g][SRC];
            end else begin : g_gap
                assign slot[b] = 1'b0;
            end
        end
        assign merge[g+1] = merge[g] | slot;
    end

    assign packed_word = merge[NFLD];

endmodule

// File: rtl/wsb_trig_sel.sv
module wsb_trig_sel #(
    parameter int                   NSUB         = 4,
    parameter wsb_pkg::trig_src_e   TRIG_SRC     = wsb_pkg::TRIG_SELF_READ,
    parameter bit                   EXT_ACT_HIGH = 1'b1
) (
    input  logic [NSUB-1:0] req_stb,
    input  logic            req_is_wr,
    input  logic            ext_trig,
    input  logic            fld_trig,
    output logic            cap_en
);

    logic unused_trig_inputs;

    if (TRIG_SRC == wsb_pkg::TRIG_SELF_READ) begin : g_self
        // Lowest sub-word (or the only one) read, not written
        assign cap_en             = req_stb[0] & ~req_is_wr;
        assign unused_trig_inputs = ^{ext_trig, fld_trig, req_stb};
    end else if (TRIG_SRC == wsb_pkg::TRIG_EXT_PIN) begin : g_ext
        if (EXT_ACT_HIGH) begin : g_hi
            assign cap_en = ext_trig;
        end else begin : g_lo
            assign cap_en = ~ext_trig;
        end
        assign unused_trig_inputs = ^{fld_trig, req_stb, req_is_wr};
    end else begin : g_fld
        assign cap_en             = fld_trig;
        assign unused_trig_inputs = ^{ext_trig, req_stb, req_is_wr};
    end

endmodule

// File: rtl/wsb_snap_reg.sv
module wsb_snap_reg #(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [REG_W-1:0] packed_word,
    output logic [REG_W-1:0] snap_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (cap_en) begin
            snap_q <= packed_word;
        end
    end

endmodule

// File: rtl/wsb_read_mux.sv
module wsb_read_mux #(
    parameter int REG_W = 64,
    parameter int ACC_W = 16
) (
    input  logic [REG_W/ACC_W-1:0] req_stb,
    input  logic                   req_is_wr,
    input  logic                   cap_en,
    input  logic [REG_W-1:0]       packed_word,
    input  logic [REG_W-1:0]       snap_q,
    output logic [ACC_W-1:0]       rd_data
);

    localparam int NSUB = REG_W / ACC_W;

    // During a capture cycle the new word is forwarded
    logic [REG_W-1:0] src_word;
    assign src_word = cap_en ? packed_word : snap_q;

    logic [NSUB:0][ACC_W-1:0] acc;
    assign acc[0] = '0;

    for (genvar k = 0; k < NSUB; k++) begin : g_sub
        logic sel;
        assign sel      = req_stb[k] & ~req_is_wr;
        assign acc[k+1] = acc[k] | ({ACC_W{sel}} & src_word[k*ACC_W +: ACC_W]);
    end

    assign rd_data = acc[NSUB];

endmodule

// File: rtl/wide_snap_buf.sv
module wide_snap_buf #(
    parameter int                 REG_W        = 64,
    parameter int                 ACC_W        = 16,
    parameter int                 NFLD         = 3,
    parameter int                 FLD_MAXW     = 16,
    parameter int                 FLD_LO  [NFLD] = '{4, 20, 40},
    parameter int                 FLD_W   [NFLD] = '{12, 16, 16},
    parameter bit                 FLD_REV [NFLD] = '{1'b0, 1'b1, 1'b0},
    parameter wsb_pkg::trig_src_e TRIG_SRC     = wsb_pkg::TRIG_SELF_READ,
    parameter bit                 EXT_ACT_HIGH = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [REG_W/ACC_W-1:0]        req_stb,
    input  logic                          req_is_wr,
    input  logic                          ext_trig,
    input  logic                          fld_trig,
    input  logic [NFLD-1:0][FLD_MAXW-1:0] fld_value,
    output logic [ACC_W-1:0]              rd_data
);

    localparam int NSUB = REG_W / ACC_W;

    logic [REG_W-1:0] packed_word;
    logic [REG_W-1:0] snap_q;
    logic             cap_en;

    wsb_field_pack #(
        .REG_W(REG_W), .NFLD(NFLD), .FLD_MAXW(FLD_MAXW),
        .FLD_LO(FLD_LO), .FLD_W(FLD_W), .FLD_REV(FLD_REV)
    ) u_pack (
        .fld_value  (fld_value),
        .packed_word(packed_word)
    );

    wsb_trig_sel #(
        .NSUB(NSUB), .TRIG_SRC(TRIG_SRC), .EXT_ACT_HIGH(EXT_ACT_HIGH)
    ) u_trig (
        .req_stb  (req_stb),
        .req_is_wr(req_is_wr),
        .ext_trig (ext_trig),
        .fld_trig (fld_trig),
        .cap_en   (cap_en)
    );

    wsb_snap_reg #(
        .REG_W(REG_W)
    ) u_snap (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .packed_word(packed_word),
        .snap_q     (snap_q)
    );

    wsb_read_mux #(
        .REG_W(REG_W), .ACC_W(ACC_W)
    ) u_rmux (
        .req_stb    (req_stb),
        .req_is_wr  (req_is_wr),
        .cap_en     (cap_en),
        .packed_word(packed_word),
        .snap_q     (snap_q),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
    parameter int                 REG_W    = 64,
    parameter int                 ACC_W    = 16,
    parameter int                 NFLD     = 3,
    parameter int                 FLD_LO [NFLD] = '{4, 20, 40},
    parameter int                 FLD_W  [NFLD] = '{12, 16, 16},
    parameter wsb_pkg::trig_src_e TRIG_SRC = wsb_pkg::TRIG_SELF_READ
) (
    input logic                   clk,
    input logic                   rst,
    input logic [REG_W/ACC_W-1:0] req_stb,
    input logic                   req_is_wr,
    input logic [ACC_W-1:0]       rd_data,
    input logic                   cap_en,
    input logic [REG_W-1:0]       packed_word,
    input logic [REG_W-1:0]       snap_q
);

    function automatic logic [REG_W-1:0] field_mask();
        logic [REG_W-1:0] m;
        logic [REG_W-1:0] one;
        m   = '0;
        one = {{(REG_W-1){1'b0}}, 1'b1};
        for (int i = 0; i < NFLD; i++) begin
            m = m | (((one << FLD_W[i]) - one) << FLD_LO[i]);
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] FIELD_MASK = field_mask();

    // R2: buffer holds outside trigger cycles
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> (snap_q == $past(snap_q)));

    // R2: buffer loads the packed word in a trigger cycle
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (snap_q == $past(packed_word)));

    // R6: uncovered positions of the packed word are zero
    p_gap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ((packed_word & ~FIELD_MASK) == '0));

    // R8: at most one sub-word strobed
    p_one_sub_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_stb));

    // R9: capturing read of sub-word 0 returns live data
    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_en && req_stb[0] && !req_is_wr) |-> (rd_data == packed_word[ACC_W-1:0]));

    // R10: no read, no data
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (req_is_wr || (req_stb == '0)) |-> (rd_data == '0));

    if (TRIG_SRC == wsb_pkg::TRIG_SELF_READ) begin : g_self_chk
        // R3: self trigger follows a read of sub-word 0 exactly
        p_self_trig_r3: assert property (@(posedge clk) disable iff (rst)
            (req_stb[0] && !req_is_wr) |-> cap_en);
        p_no_trig_r3: assert property (@(posedge clk) disable iff (rst)
            !(req_stb[0] && !req_is_wr) |-> !cap_en);
    end

endmodule

bind wide_snap_buf wsb_checker #(
    .REG_W(REG_W), .ACC_W(ACC_W), .NFLD(NFLD),
    .FLD_LO(FLD_LO), .FLD_W(FLD_W), .TRIG_SRC(TRIG_SRC)
) u_wsb_checker (
    .clk        (clk),
    .rst        (rst),
    .req_stb    (req_stb),
    .req_is_wr  (req_is_wr),
    .rd_data    (rd_data),
    .cap_en     (cap_en),
    .packed_word(packed_word),
    .snap_q     (snap_q)
);

// File: tb/wide_snap_buf_tb_top.sv
module wide_snap_buf_tb_top;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      req_stb = '0;
    logic            req_is_wr = 1'b0;
    logic            ext_trig = 1'b1;
    logic            fld_trig = 1'b0;
    logic [2:0][15:0] fld_value = '0;
    logic [15:0]     rd_i, rd_e, rd_f;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Self-read trigger (default)
    wide_snap_buf dut_i (
        .clk(clk), .rst(rst), .req_stb(req_stb), .req_is_wr(req_is_wr),
        .ext_trig(ext_trig), .fld_trig(fld_trig), .fld_value(fld_value),
        .rd_data(rd_i));

    // External pin, active low
    wide_snap_buf #(.TRIG_SRC(wsb_pkg::TRIG_EXT_PIN), .EXT_ACT_HIGH(1'b0)) dut_ext (
        .clk(clk), .rst(rst), .req_stb(req_stb), .req_is_wr(req_is_wr),
        .ext_trig(ext_trig), .fld_trig(fld_trig), .fld_value(fld_value),
        .rd_data(rd_e));

    // Field-bit trigger
    wide_snap_buf #(.TRIG_SRC(wsb_pkg::TRIG_FIELD_BIT)) dut_fld (
        .clk(clk), .rst(rst), .req_stb(req_stb), .req_is_wr(req_is_wr),
        .ext_trig(ext_trig), .fld_trig(fld_trig), .fld_value(fld_value),
        .rd_data(rd_f));

    // Expected packing from R6/R7 layout
    function automatic logic [63:0] pack_ref(input logic [15:0] f0, f1, f2);
        logic [63:0] w;
        w = '0;
        w[15:4] = f0[11:0];
        for (int b = 0; b < 16; b++) w[20+b] = f1[15-b];
        w[55:40] = f2;
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge; sample 1 time unit later
    task automatic drive(input logic [3:0] stb, input logic wr,
                         input logic [15:0] f0, f1, f2,
                         input logic ext, input logic fb);
        @(negedge clk);
        req_stb   = stb;
        req_is_wr = wr;
        fld_value = {f2, f1, f0};
        ext_trig  = ext;
        fld_trig  = fb;
        #1;
    endtask

    logic [63:0] last_i, last_e;

    initial begin
        logic [15:0] a0, a1, a2;
        logic [63:0] pw;
        last_i = '0;
        last_e = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state on all sub-words without capture
        for (int k = 1; k < 4; k++) begin
            drive(4'b0001 << k, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
            check("R1 self reset", rd_i, 16'h0);
            check("R1 ext reset", rd_e, 16'h0);
            check("R1 fld reset", rd_f, 16'h0);
        end

        // Main sweep: capture at sub-word 0, then change fields between reads
        for (int it = 0; it < 64; it++) begin
            a0 = 16'($urandom); a1 = 16'($urandom); a2 = 16'($urandom);
            pw = pack_ref(a0, a1, a2);
            drive(4'b0001, 1'b0, a0, a1, a2, 1'b1, 1'b0);
            check("R9 capture read sub0", rd_i, pw[15:0]);
            check("R4 ext inactive level", rd_e, last_e[15:0]);
            check("R5 fld idle", rd_f, 16'h0);
            last_i = pw;
            for (int k = 1; k < 4; k++) begin
                drive(4'b0001 << k, 1'b0, 16'($urandom), 16'($urandom), 16'($urandom), 1'b1, 1'b0);
                check("R2 R8 snapshot sub-word", rd_i, last_i[k*16 +: 16]);
            end
            drive(4'b0001, 1'b1, 16'($urandom), 16'($urandom), 16'($urandom), 1'b1, 1'b0);
            check("R10 write returns zero", rd_i, 16'h0);
            drive(4'b1000, 1'b0, 16'($urandom), 16'($urandom), 16'($urandom), 1'b1, 1'b0);
            check("R3 write to sub0 no capture", rd_i, last_i[63:48]);
            drive(4'b0000, 1'b0, 16'($urandom), 16'($urandom), 16'($urandom), 1'b1, 1'b0);
            check("R10 idle returns zero", rd_i, 16'h0);
        end

        // R4: external active-low trigger
        a0 = 16'h1234; a1 = 16'hA5C3; a2 = 16'h0FF0;
        drive(4'b0000, 1'b0, 16'h1111, 16'h2222, 16'h3333, 1'b0, 1'b0);
        drive(4'b0010, 1'b0, a0, a1, a2, 1'b0, 1'b0);
        pw = pack_ref(a0, a1, a2);
        check("R9 ext bypass sub1", rd_e, pw[31:16]);
        check("R3 self no capture on sub1 read", rd_i, last_i[31:16]);
        last_e = pw;
        drive(4'b0100, 1'b0, 16'hDEAD, 16'hBEEF, 16'hCAFE, 1'b1, 1'b0);
        check("R4 ext snapshot held", rd_e, last_e[47:32]);
        check("R4 ext pin no effect on self", rd_i, last_i[47:32]);

        // R5: field-bit trigger during a write, no strobe
        a0 = 16'h0ABC; a1 = 16'h8001; a2 = 16'h7E81;
        drive(4'b0000, 1'b1, a0, a1, a2, 1'b1, 1'b1);
        drive(4'b1000, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        pw = pack_ref(a0, a1, a2);
        check("R5 fld capture", rd_f, pw[63:48]);
        check("R5 fld bit no effect on ext", rd_e, last_e[63:48]);
        drive(4'b0010, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R5 fld snapshot sub1", rd_f, pw[31:16]);

        // R6: all-ones fields expose gap bits
        drive(4'b0001, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        check("R6 gaps sub0", rd_i, 16'hFFF0);
        drive(4'b0010, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R6 gaps sub1", rd_i, 16'hFFF0);
        drive(4'b0100, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R6 gaps sub2", rd_i, 16'hFF0F);
        drive(4'b1000, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R6 gaps sub3", rd_i, 16'h00FF);

        // R7: reversed field, single bits
        drive(4'b0001, 1'b0, 16'h0, 16'h0001, 16'h0, 1'b1, 1'b0);
        check("R7 lane bit0 sub0", rd_i, 16'h0000);
        drive(4'b0100, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R7 lane bit0 to word bit35", rd_i, 16'h0008);
        drive(4'b0001, 1'b0, 16'h0, 16'h8000, 16'h0, 1'b1, 1'b0);
        drive(4'b0010, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R7 lane bit15 to word bit20", rd_i, 16'h0010);
        drive(4'b0100, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        check("R7 lane bit15 sub2 clear", rd_i, 16'h0000);

        // R1: mid-run reset clears the buffers
        drive(4'b0001, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        @(negedge clk);
        req_stb = 4'b0000;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(4'b0100, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
        check("R1 self cleared", rd_i, 16'h0);
        check("R1 ext cleared", rd_e, 16'h0);
        check("R1 fld cleared", rd_f, 16'h0);

        drive(4'b0000, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule